// File: doc/BRIEF.md
# Lane Fetch Command Sequencer

This block sits at the front of one lane in a multi-lane vector-thread unit. It takes two kinds of fetch command. A vector-fetch carries a block address. A thread-fetch carries a block address and the global number of the virtual processor (VP) that asked for it. The block checks the address against a small direct-mapped tag store for the lane's instruction-block cache. On a miss it presents the address to a fill agent and waits for the fill to complete. It then emits execute directives, each pairing the block address with a global VP number, to the lane's in-order execution cluster under a valid/ready handshake.

VPs are interleaved across the lanes, so this lane owns the global VPs whose number modulo the lane count equals its lane index. How many VPs each lane holds depends on how the per-cluster register file is split. Part of it is shared, and the remainder is divided into equal private slices, one per VP. A fetched block runs to completion for all of its VPs before the sequencer takes another command. The cluster reports completion with a one-cycle done pulse.

Top module: `lane_fetch_seq`

## Requirements
- R1: After reset the lane holds 4 VPs, which is the count for 0 shared and 8 private registers. An accepted configuration (`cfg_valid` high with `cfg_private` nonzero) sets `vp_count` to (32 − `cfg_shared`) / `cfg_private`, rounded down and capped at 32, from the next cycle. Examples: 4/4 gives 7, 7/1 gives 25, 31/2 gives 0.
- R2: A configuration with `cfg_private` equal to 0 is rejected. `cfg_err` goes high the next cycle and `vp_count` keeps its old value. The next accepted configuration clears `cfg_err`.
- R3: A vector-fetch produces exactly `vp_count` directives, in ascending local order. Directive k carries global VP 4·k + LANE_ID and the command's address. No further directive follows.
- R4: A valid thread-fetch produces exactly one directive, carrying the requesting VP number and the command's address.
- R5: A thread-fetch is dropped when its VP number modulo 4 differs from LANE_ID, or when its VP number divided by 4 is not below `vp_count`. A dropped command produces no directive and no miss, `cmd_drop` pulses in the cycle after acceptance, and `cmd_ready` stays high.
- R6: On a tag miss, `miss_valid` rises with `miss_addr` equal to the command address. It stays high until `fill_valid` is sampled, and no directive is presented while it is high.
- R7: The tag store is direct-mapped over TAG_SETS sets indexed by the low address bits, and it is empty after reset. A filled address hits on its next fetch. A fill for another address with the same index evicts it.
- R8: `cmd_ready` is low from the acceptance of a non-dropped command until the cycle after `blk_done` is sampled following its last directive. A vector-fetch with `vp_count` 0 is accepted with no directive and leaves `cmd_ready` high.
- R9: While `dir_valid` is high and `dir_ready` is low, `dir_valid`, `dir_vp` and `dir_addr` hold their values.
- R10: After reset, `cmd_ready` is 1, and `dir_valid`, `miss_valid`, `cmd_drop` and `cfg_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Apply a register split this cycle |
| cfg_shared | input | 5 | Shared registers per cluster |
| cfg_private | input | 6 | Private registers per VP |
| vp_count | output | 6 | VPs held by this lane |
| cfg_err | output | 1 | Last configuration was rejected |
| cmd_valid | input | 1 | Fetch command present |
| cmd_ready | output | 1 | Sequencer idle and accepting |
| cmd_is_thread | input | 1 | 1 for thread-fetch, 0 for vector-fetch |
| cmd_addr | input | 16 | Instruction block address |
| cmd_vp | input | 7 | Global VP number (thread-fetch only) |
| cmd_drop | output | 1 | One-cycle pulse for a dropped thread-fetch |
| miss_valid | output | 1 | Block fill requested |
| miss_addr | output | 16 | Address of the missing block |
| fill_valid | input | 1 | Fill of the requested block done |
| dir_valid | output | 1 | Execute directive present |
| dir_ready | input | 1 | Cluster accepts the directive |
| dir_addr | output | 16 | Block address of the directive |
| dir_vp | output | 7 | Global VP number of the directive |
| blk_done | input | 1 | Cluster finished the launched block |

## Verification
The bench targets the edges of the per-lane VP range. It issues thread-fetches for a VP of another lane and for a local index exactly equal to the count. A sequencer with an off-by-one bound would launch the second of these. It sets a split that leaves zero VPs, where a sequencer that issues before testing would emit a stray directive or hang. A zero-private configuration must leave the old count in place rather than load garbage. Stalls on `dir_ready` expose a counter that advances without the handshake, which would skip or repeat VPs. Two addresses that share a set expose a tag store that ignores the tag bits, which would wrongly hit after eviction.

// File: rtl/lfs_pkg.sv
package lfs_pkg;

    localparam int LFS_REGS      = 32;
    localparam int LFS_LANES     = 4;
    localparam int LFS_MAX_VP    = 128;
    localparam int LFS_ADDR_W    = 16;

    localparam int LFS_SH_W      = $clog2(LFS_REGS);
    localparam int LFS_PR_W      = $clog2(LFS_REGS + 1);
    localparam int LFS_PER_LANE  = LFS_MAX_VP / LFS_LANES;
    localparam int LFS_CNT_W     = $clog2(LFS_PER_LANE + 1);
    localparam int LFS_VP_W      = $clog2(LFS_MAX_VP);
    localparam int LFS_LANE_W    = $clog2(LFS_LANES);
    localparam int LFS_LIDX_W    = LFS_VP_W - LFS_LANE_W;

    localparam int LFS_RST_PRIV  = 8;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_CHECK,
        SEQ_MISS,
        SEQ_ISSUE,
        SEQ_WAIT
    } seq_state_e;

    typedef struct packed {
        logic                   thread;
        logic [LFS_ADDR_W-1:0]  addr;
        logic [LFS_LIDX_W-1:0]  idx;
        logic [LFS_LIDX_W-1:0]  last;
    } job_t;

    function automatic logic [LFS_CNT_W-1:0] vps_per_lane(
        input logic [LFS_SH_W-1:0] shared_regs,
        input logic [LFS_PR_W-1:0] priv_regs
    );
        int q;
        if (priv_regs == '0) begin
            q = 0;
        end else begin
            q = (LFS_REGS - int'(shared_regs)) / int'(priv_regs);
        end
        if (q > LFS_PER_LANE) q = LFS_PER_LANE;
        return LFS_CNT_W'(q);
    endfunction

endpackage

// File: rtl/lfs_vp_cfg.sv
module lfs_vp_cfg
    import lfs_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_valid,
    input  logic [LFS_SH_W-1:0]   cfg_shared,
    input  logic [LFS_PR_W-1:0]   cfg_private,
    output logic [LFS_CNT_W-1:0]  vp_count,
    output logic                  cfg_err
);

    localparam logic [LFS_CNT_W-1:0] RST_COUNT =
        LFS_CNT_W'(LFS_REGS / LFS_RST_PRIV);

    always_ff @(posedge clk) begin
        if (rst) begin
            vp_count <= RST_COUNT;
            cfg_err  <= 1'b0;
        end else if (cfg_valid) begin
            if (cfg_private == '0) begin
                cfg_err <= 1'b1;
            end else begin
                cfg_err  <= 1'b0;
                vp_count <= vps_per_lane(cfg_shared, cfg_private);
            end
        end
    end

    // R2: a zero private split is refused and the count survives
    a_r2_reject_keeps: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid && cfg_private == '0) |=> (cfg_err && $stable(vp_count)));

    // R2: an accepted split clears the error
    a_r2_accept_clears: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid && cfg_private != '0) |=> !cfg_err);

endmodule

// File: rtl/lfs_tags.sv
module lfs_tags
    import lfs_pkg::*;
#(
    parameter int SETS = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [LFS_ADDR_W-1:0]  lk_addr,
    output logic                   hit,
    input  logic                   wr_en,
    input  logic [LFS_ADDR_W-1:0]  wr_addr
);

    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int TAG_W = LFS_ADDR_W - IDX_W;

    logic [SETS-1:0]  set_hit;
    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] wr_idx;

    assign lk_idx = lk_addr[IDX_W-1:0];
    assign wr_idx = wr_addr[IDX_W-1:0];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        logic             vld;
        logic [TAG_W-1:0] tag;

        always_ff @(posedge clk) begin
            if (rst) begin
                vld <= 1'b0;
                tag <= '0;
            end else if (wr_en && wr_idx == IDX_W'(s)) begin
                vld <= 1'b1;
                tag <= wr_addr[LFS_ADDR_W-1:IDX_W];
            end
        end

        assign set_hit[s] = vld && (lk_idx == IDX_W'(s))
                            && (tag == lk_addr[LFS_ADDR_W-1:IDX_W]);
    end

    assign hit = |set_hit;

    // R7: at most one set can claim a lookup
    a_r7_one_set: assert property (@(posedge clk) disable iff (rst)
        $onehot0(set_hit));

endmodule

// File: rtl/lane_fetch_seq.sv
module lane_fetch_seq
    import lfs_pkg::*;
#(
    parameter int LANE_ID  = 0,
    parameter int TAG_SETS = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_valid,
    input  logic [LFS_SH_W-1:0]    cfg_shared,
    input  logic [LFS_PR_W-1:0]    cfg_private,
    output logic [LFS_CNT_W-1:0]   vp_count,
    output logic                   cfg_err,
    input  logic                   cmd_valid,
    output logic                   cmd_ready,
    input  logic                   cmd_is_thread,
    input  logic [LFS_ADDR_W-1:0]  cmd_addr,
    input  logic [LFS_VP_W-1:0]    cmd_vp,
    output logic                   cmd_drop,
    output logic                   miss_valid,
    output logic [LFS_ADDR_W-1:0]  miss_addr,
    input  logic                   fill_valid,
    output logic                   dir_valid,
    input  logic                   dir_ready,
    output logic [LFS_ADDR_W-1:0]  dir_addr,
    output logic [LFS_VP_W-1:0]    dir_vp,
    input  logic                   blk_done
);

    localparam logic [LFS_LANE_W-1:0] LANE_BITS = LFS_LANE_W'(LANE_ID);

    seq_state_e state;
    job_t       job;
    logic       tag_hit;
    logic       accept;
    logic       thr_ok;
    logic       drop_now;
    logic [LFS_LIDX_W-1:0] req_idx;

    lfs_vp_cfg u_cfg (
        .clk         (clk),
        .rst         (rst),
        .cfg_valid   (cfg_valid),
        .cfg_shared  (cfg_shared),
        .cfg_private (cfg_private),
        .vp_count    (vp_count),
        .cfg_err     (cfg_err)
    );

    lfs_tags #(.SETS(TAG_SETS)) u_tags (
        .clk     (clk),
        .rst     (rst),
        .lk_addr (job.addr),
        .hit     (tag_hit),
        .wr_en   (state == SEQ_MISS && fill_valid),
        .wr_addr (job.addr)
    );

    assign cmd_ready = (state == SEQ_IDLE);
    assign accept    = cmd_valid && cmd_ready;
    assign req_idx   = cmd_vp[LFS_VP_W-1:LFS_LANE_W];
    assign thr_ok    = (cmd_vp[LFS_LANE_W-1:0] == LANE_BITS)
                       && ({1'b0, req_idx} < LFS_LIDX_W'(0) + {1'b0, vp_count[LFS_CNT_W-2:0]} + (vp_count[LFS_CNT_W-1] ? (LFS_LIDX_W+1)'(1 << (LFS_CNT_W-1)) : '0));
    assign drop_now  = accept && cmd_is_thread && !thr_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SEQ_IDLE;
            job      <= '0;
            cmd_drop <= 1'b0;
        end else begin
            cmd_drop <= drop_now;
            unique case (state)
                SEQ_IDLE: begin
                    if (accept && !drop_now) begin
                        if (cmd_is_thread) begin
                            job.thread <= 1'b1;
                            job.addr   <= cmd_addr;
                            job.idx    <= req_idx;
                            job.last   <= req_idx;
                            state      <= SEQ_CHECK;
                        end else if (vp_count != '0) begin
                            job.thread <= 1'b0;
                            job.addr   <= cmd_addr;
                            job.idx    <= '0;
                            job.last   <= LFS_LIDX_W'(vp_count - 1'b1);
                            state      <= SEQ_CHECK;
                        end
                    end
                end
                SEQ_CHECK: state <= tag_hit ? SEQ_ISSUE : SEQ_MISS;
                SEQ_MISS:  if (fill_valid) state <= SEQ_ISSUE;
                SEQ_ISSUE: begin
                    if (dir_ready) begin
                        if (job.idx == job.last) state <= SEQ_WAIT;
                        else job.idx <= job.idx + 1'b1;
                    end
                end
                SEQ_WAIT:  if (blk_done) state <= SEQ_IDLE;
                default:   state <= SEQ_IDLE;
            endcase
        end
    end

    assign miss_valid = (state == SEQ_MISS);
    assign miss_addr  = job.addr;
    assign dir_valid  = (state == SEQ_ISSUE);
    assign dir_addr   = job.addr;
    assign dir_vp     = {job.idx, LANE_BITS};

    // R9: a stalled directive holds steady
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (dir_valid && !dir_ready) |=> (dir_valid && $stable(dir_vp) && $stable(dir_addr)));

    // R6: no directive while a fill is outstanding
    a_r6_no_dir_in_miss: assert property (@(posedge clk) disable iff (rst)
        miss_valid |-> !dir_valid);

    // R6: miss request persists until the fill arrives
    a_r6_miss_held: assert property (@(posedge clk) disable iff (rst)
        (miss_valid && !fill_valid) |=> (miss_valid && $stable(miss_addr)));

    // R7: a completed fill makes the same block hit
    a_r7_fill_hits: assert property (@(posedge clk) disable iff (rst)
        (miss_valid && fill_valid) |=> tag_hit);

    // R8: no new command while directives are pending
    a_r8_busy: assert property (@(posedge clk) disable iff (rst)
        dir_valid |-> !cmd_ready);

    // R5: a thread-fetch for another lane is dropped and leaves the sequencer idle
    a_r5_foreign_drop: assert property (@(posedge clk) disable iff (rst)
        (accept && cmd_is_thread && cmd_vp[LFS_LANE_W-1:0] != LANE_BITS)
        |=> (cmd_drop && cmd_ready));

endmodule

// File: tb/sim_lane_fetch_seq.sv
module sim_lane_fetch_seq;
    import lfs_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int LANE       = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_valid = 1'b0;
    logic [LFS_SH_W-1:0] cfg_shared = '0;
    logic [LFS_PR_W-1:0] cfg_private = '0;
    logic [LFS_CNT_W-1:0] vp_count;
    logic cfg_err;
    logic cmd_valid = 1'b0;
    logic cmd_ready;
    logic cmd_is_thread = 1'b0;
    logic [LFS_ADDR_W-1:0] cmd_addr = '0;
    logic [LFS_VP_W-1:0] cmd_vp = '0;
    logic cmd_drop;
    logic miss_valid;
    logic [LFS_ADDR_W-1:0] miss_addr;
    logic fill_valid = 1'b0;
    logic dir_valid;
    logic dir_ready = 1'b0;
    logic [LFS_ADDR_W-1:0] dir_addr;
    logic [LFS_VP_W-1:0] dir_vp;
    logic blk_done = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_fetch_seq #(.LANE_ID(LANE), .TAG_SETS(4)) u0 (
        .clk(clk), .rst(rst),
        .cfg_valid(cfg_valid), .cfg_shared(cfg_shared), .cfg_private(cfg_private),
        .vp_count(vp_count), .cfg_err(cfg_err),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_is_thread(cmd_is_thread),
        .cmd_addr(cmd_addr), .cmd_vp(cmd_vp), .cmd_drop(cmd_drop),
        .miss_valid(miss_valid), .miss_addr(miss_addr), .fill_valid(fill_valid),
        .dir_valid(dir_valid), .dir_ready(dir_ready), .dir_addr(dir_addr),
        .dir_vp(dir_vp), .blk_done(blk_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic set_cfg(input int sh, input int pr);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_shared = LFS_SH_W'(sh); cfg_private = LFS_PR_W'(pr);
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    // Run one accepted command to completion; checks R3/R4/R6/R7/R8/R9
    task automatic run_cmd(input bit thr, input int addr, input int vp,
                           input bit stall, input int exp_n, input bit exp_miss,
                           input string tag);
        int n = 0, misses = 0, bad = 0, unstable = 0, overlap = 0, cyc = 0;
        bit have_hold = 0, maddr_ok = 1;
        logic [LFS_VP_W-1:0] held_vp = '0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_is_thread = thr;
        cmd_addr = LFS_ADDR_W'(addr); cmd_vp = LFS_VP_W'(vp);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(!cmd_ready, {"R8 busy after accept ", tag}, int'(cmd_ready), 0);
        while (n < exp_n && cyc < 500) begin
            cyc++;
            fill_valid = 1'b0;
            if (miss_valid) begin
                misses++;
                if (miss_addr != LFS_ADDR_W'(addr)) maddr_ok = 0;
                if (dir_valid) overlap++;
                if (misses >= 2) fill_valid = 1'b1;
            end
            dir_ready = stall ? (cyc % 3 != 0) : 1'b1;
            if (have_hold && (!dir_valid || dir_vp != held_vp)) unstable++;
            have_hold = 0;
            if (dir_valid) begin
                if (dir_ready) begin
                    int e;
                    e = thr ? vp : (LANE + 4 * n);
                    if (int'(dir_vp) != e || dir_addr != LFS_ADDR_W'(addr)) begin
                        bad++;
                        $display("FAIL R3/R4 %s: directive %0d actual vp %0d expected %0d",
                                 tag, n, dir_vp, e);
                    end
                    n++;
                end else begin
                    have_hold = 1; held_vp = dir_vp;
                end
            end
            @(negedge clk);
        end
        fill_valid = 1'b0; dir_ready = 1'b0;
        chk(n == exp_n, {"R3/R4 directive count ", tag}, n, exp_n);
        chk(bad == 0, {"R3/R4 directive content ", tag}, bad, 0);
        chk((misses > 0) == exp_miss, {"R7 hit/miss ", tag}, int'(misses > 0), int'(exp_miss));
        if (exp_miss) begin
            chk(maddr_ok, {"R6 miss address ", tag}, int'(maddr_ok), 1);
            chk(misses >= 2, {"R6 miss held until fill ", tag}, misses, 2);
        end
        chk(overlap == 0, {"R6 no directive during miss ", tag}, overlap, 0);
        if (stall) chk(unstable == 0, {"R9 stalled directive held ", tag}, unstable, 0);
        @(negedge clk);
        chk(!dir_valid && !cmd_ready, {"R8 waiting for done ", tag},
            int'(dir_valid) + 2 * int'(cmd_ready), 0);
        blk_done = 1'b1;
        @(negedge clk);
        blk_done = 1'b0;
        chk(cmd_ready, {"R8 ready after done ", tag}, int'(cmd_ready), 1);
    endtask

    // Command that must not launch anything (drop or zero-count vector)
    task automatic run_nolaunch(input bit thr, input int vp, input bit exp_drop,
                                input string req);
        int seen = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_is_thread = thr; cmd_addr = 16'h0100;
        cmd_vp = LFS_VP_W'(vp);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(cmd_drop == exp_drop, {req, " drop pulse"}, int'(cmd_drop), int'(exp_drop));
        chk(cmd_ready, {req, " stays ready"}, int'(cmd_ready), 1);
        for (int i = 0; i < 4; i++) begin
            if (dir_valid || miss_valid) seen++;
            @(negedge clk);
        end
        chk(seen == 0, {req, " nothing launched"}, seen, 0);
        chk(!cmd_drop, {req, " drop is one cycle"}, int'(cmd_drop), 0);
    endtask

    task automatic t_reset;
        chk(cmd_ready, "R10 cmd_ready", int'(cmd_ready), 1);
        chk(!dir_valid && !miss_valid, "R10 outputs idle",
            int'(dir_valid) + int'(miss_valid), 0);
        chk(!cmd_drop && !cfg_err, "R10 flags clear", int'(cmd_drop) + int'(cfg_err), 0);
        chk(vp_count == 4, "R1 reset count", int'(vp_count), 4);
    endtask

    task automatic t_config;
        set_cfg(4, 4);
        chk(vp_count == 7, "R1 split 4/4", int'(vp_count), 7);
        set_cfg(3, 0);
        chk(cfg_err, "R2 reject flag", int'(cfg_err), 1);
        chk(vp_count == 7, "R2 count kept", int'(vp_count), 7);
        set_cfg(7, 1);
        chk(!cfg_err, "R2 flag cleared", int'(cfg_err), 0);
        chk(vp_count == 25, "R1 split 7/1", int'(vp_count), 25);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        run_cmd(0, 16'h0040, 0, 0, 4, 1, "vector cold");          // R3 R6
        run_cmd(0, 16'h0040, 0, 1, 4, 0, "vector warm stalled");  // R7 R9
        set_cfg(4, 4);
        chk(vp_count == 7, "R1 split 4/4 live", int'(vp_count), 7);
        run_cmd(0, 16'h0040, 0, 1, 7, 0, "vector seven");         // R3
        run_cmd(1, 16'h0041, 10, 0, 1, 1, "thread vp10");         // R4
        run_nolaunch(1, 11, 1, "R5 foreign lane");
        run_nolaunch(1, 30, 1, "R5 index equals count");
        run_cmd(1, 16'h0041, 26, 0, 1, 0, "thread last local");   // R4 R5 bound
        t_config();
        run_cmd(1, 16'h0044, 98, 0, 1, 1, "thread evict");        // R7
        run_cmd(0, 16'h0040, 0, 0, 25, 1, "vector after evict");  // R7 R3
        set_cfg(31, 2);
        chk(vp_count == 0, "R1 split 31/2", int'(vp_count), 0);
        run_nolaunch(0, 0, 0, "R8 zero-count vector");
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule